// File: doc/BRIEF.md
# SDRAM Burst Termination Scheduler

This block issues READ and WRITE bursts to an already open SDRAM row and can cut a running burst short, either with a burst-stop command or with a precharge. It sits between a transaction front end and the SDRAM command pins. It drives the command pins and the write mask. It also produces two strobes. One marks each write beat that is really stored. The other marks each read beat that really arrives, so the data path knows exactly how many beats survive a truncation.

The front end pulses `act_i` in the cycle it opens the row. It pulses `start_i` with direction and burst-length code to launch a burst. Later it may pulse `term_i` to end the burst. A truncating precharge is held back until both the write-recovery time and the row-active minimum are met. A request that comes too late to shorten anything is dropped and flagged.

Burst cycle k means k clock cycles after the cycle carrying the READ or WRITE command. Beat i of a write is driven in burst cycle i. Beat i of a read appears in burst cycle CL+i.

Top module: `sdram_burst_term`

## Requirements
- R1: While `rst_ni` is low, `cs_n_o`, `ras_n_o`, `cas_n_o` and `we_n_o` are high, and `dqm_o`, `wr_take_o`, `rvalid_o`, `term_late_o` and `busy_o` are low. After reset, `cs_n_o` is low and the pins show NOP, with (ras_n, cas_n, we_n) = (1,1,1).
- R2: When `start_i` is sampled high at an edge where `busy_o` is low, the next cycle (burst cycle 0) carries READ (1,0,1) if `start_wr_i`=0 or WRITE (1,0,0) if `start_wr_i`=1. The burst length is 1, 2, 4 or 8 for `bl_sel_i` = 0, 1, 2 or 3. A `start_i` sampled while `busy_o` is high is ignored. `busy_o` is high from burst cycle 0 to the last valid read beat or the last cycle before the closing command, whichever is later.
- R3: A write that is not terminated asserts `wr_take_o` in burst cycles 0 to BL-1, and `dqm_o` stays low.
- R4: A read that is not terminated asserts `rvalid_o` in burst cycles CL to CL+BL-1. CL is 2 when `cas_lat3_i`=0 and 3 when it is 1.
- R5: An accepted stop (`term_pre_i`=0) sampled in burst cycle c of a write puts BURST STOP (1,1,0) on the pins in cycle c+1. Beats 0 to c are taken, no later beat is taken, and `dqm_o` stays low.
- R6: An accepted stop sampled in burst cycle c of a read puts BURST STOP in cycle c+1. Only beats 0 to c assert `rvalid_o`, so CL-1 valid beats follow the stop cycle.
- R7: An accepted precharge (`term_pre_i`=1) sampled in burst cycle c of a write puts PRECHARGE (0,1,0) in cycle p = max(c + `trdl_i`, the first cycle allowed by R9). Beats 0 to c are taken, and `dqm_o` is high on beats c+1 to min(BL,p)-1.
- R8: An accepted precharge sampled in burst cycle c of a read puts PRECHARGE in cycle p = max(c+1, the first cycle allowed by R9). Beats i < min(p,BL) assert `rvalid_o`.
- R9: PRECHARGE never appears fewer than `tras_i` cycles after the cycle in which `act_i` was high. A pending precharge waits until that point.
- R10: `term_i` is accepted only while a burst is in cycle c ≤ BL-2 and no earlier request was accepted for that burst. Any other `term_i` leaves the pins, `dqm_o`, `wr_take_o` and `rvalid_o` unchanged, and gives a one-cycle `term_late_o` pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Row was activated in this cycle |
| start_i | input | 1 | Launch a burst |
| start_wr_i | input | 1 | 1 = write burst, 0 = read burst |
| bl_sel_i | input | 2 | Burst length code (1, 2, 4, 8) |
| term_i | input | 1 | Request to end the running burst |
| term_pre_i | input | 1 | 1 = end with precharge, 0 = end with burst stop |
| cas_lat3_i | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| trdl_i | input | TRDL_W | Last write beat to precharge, in cycles (1 or more) |
| tras_i | input | RAS_W | Minimum cycles from activate to precharge |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dqm_o | output | 1 | Write data mask |
| wr_take_o | output | 1 | Current write beat is stored |
| rvalid_o | output | 1 | Current read beat is valid |
| term_late_o | output | 1 | Terminate request was dropped |
| busy_o | output | 1 | Burst or its read data still in progress |

## Verification
Two functions meet in one cycle here. The first is the natural end of a burst, or the release of the row-active timer. The second is a termination request landing on the same beat. The bench places a stop or a precharge request on every beat from the start cycle through one past the last beat, for every burst length and both CAS latencies. It then sees which side wins: the request at beat BL-2 must still shorten the burst, and the one at BL-1 must be dropped with a status pulse. Precharge cases alternate between a timer that is already satisfied and one that holds the command past the requested point. A behavioural model predicts the command cycle, the masked beats and the surviving read beats, and these are compared with the pins on every cycle.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  // values are the (ras_n, cas_n, we_n) pin pattern
  typedef enum logic [2:0] {
    CMD_PRE = 3'b010,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  function automatic logic [3:0] bl_decode(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction
endpackage

// File: rtl/sbt_ras_timer.sv
module sbt_ras_timer #(
  parameter int RAS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [RAS_W-1:0] tras_i,
  output logic             ok_o
);
  logic [RAS_W-1:0] cnt_q;
  logic [RAS_W:0]   next_age;

  // saturates so an old open row always satisfies the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '1;
    else if (act_i)           cnt_q <= RAS_W'(1);
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  // ok_o: a command registered now lands legally next cycle
  assign next_age = {1'b0, cnt_q} + (RAS_W+1)'(1);
  assign ok_o     = next_age >= {1'b0, tras_i};
endmodule

// File: rtl/sbt_rvalid_line.sv
module sbt_rvalid_line #(
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [CL_W-1:0] cl_i,
  output logic            valid_o,
  output logic            inflight_o
);
  logic [MAX_CL-1:0] sr_q, live, tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[MAX_CL-2:0], push_i};
  end

  for (genvar k = 0; k < MAX_CL; k++) begin : g_tap
    assign live[k] = sr_q[k] & (CL_W'(k) < cl_i);
    assign tap[k]  = sr_q[k] & (CL_W'(k + 1) == cl_i);
  end

  assign valid_o    = |tap;
  assign inflight_o = |live;
endmodule

// File: rtl/sdram_burst_term.sv
module sdram_burst_term
  import sbt_pkg::*;
#(
  parameter int RAS_W  = 6,
  parameter int TRDL_W = 2,
  parameter int MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              start_i,
  input  logic              start_wr_i,
  input  logic [1:0]        bl_sel_i,
  input  logic              term_i,
  input  logic              term_pre_i,
  input  logic              cas_lat3_i,
  input  logic [TRDL_W-1:0] trdl_i,
  input  logic [RAS_W-1:0]  tras_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              dqm_o,
  output logic              wr_take_o,
  output logic              rvalid_o,
  output logic              term_late_o,
  output logic              busy_o
);
  localparam int CNT_W = RAS_W + 2;
  localparam int CL_W  = $clog2(MAX_CL + 1);

  cmd_e             cmd_q;
  logic             cs_q, run_q, pend_q, wr_q, cl3_q, late_q;
  logic [3:0]       bl_q;
  logic [CNT_W-1:0] cnt_q, tgt_q, nb_q;

  logic             ras_ok, rd_inflight, push;
  logic             start_ok, can_term, acc, stop_acc, pre_acc, pre_fire;
  logic [CNT_W-1:0] cnt_n, bl_w, tgt_new, tgt_eff;
  logic [CL_W-1:0]  cl_val;

  sbt_ras_timer #(.RAS_W(RAS_W)) u_ras (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_i),
    .tras_i (tras_i),
    .ok_o   (ras_ok)
  );

  assign cl_val = cl3_q ? CL_W'(3) : CL_W'(2);

  sbt_rvalid_line #(.MAX_CL(MAX_CL), .CL_W(CL_W)) u_rv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .cl_i       (cl_val),
    .valid_o    (rvalid_o),
    .inflight_o (rd_inflight)
  );

  assign busy_o   = run_q | pend_q | rd_inflight;
  assign start_ok = start_i & ~busy_o;
  assign cnt_n    = cnt_q + 1'b1;
  assign bl_w     = CNT_W'(bl_q);

  // a request must leave at least one beat to cut
  assign can_term = run_q & ~pend_q & ((cnt_q + CNT_W'(2)) <= bl_w);
  assign acc      = term_i & can_term;
  assign stop_acc = acc & ~term_pre_i;
  assign pre_acc  = acc & term_pre_i;
  assign tgt_new  = cnt_q + (wr_q ? CNT_W'(trdl_i) : CNT_W'(1));
  assign tgt_eff  = pend_q ? tgt_q : tgt_new;
  assign pre_fire = (pend_q | pre_acc) & (cnt_n >= tgt_eff) & ras_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      cs_q   <= 1'b1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      cl3_q  <= 1'b0;
      late_q <= 1'b0;
      bl_q   <= 4'd1;
      cnt_q  <= '0;
      tgt_q  <= '0;
      nb_q   <= '0;
    end else begin
      cs_q   <= 1'b0;
      cmd_q  <= CMD_NOP;
      late_q <= term_i & ~acc;
      if (start_ok) begin
        cmd_q  <= start_wr_i ? CMD_WR : CMD_RD;
        run_q  <= 1'b1;
        pend_q <= 1'b0;
        wr_q   <= start_wr_i;
        cl3_q  <= cas_lat3_i;
        bl_q   <= bl_decode(bl_sel_i);
        nb_q   <= CNT_W'(bl_decode(bl_sel_i));
        cnt_q  <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_n;
        if (stop_acc) begin
          cmd_q <= CMD_BST;
          run_q <= 1'b0;
        end else if (pre_fire) begin
          cmd_q  <= CMD_PRE;
          run_q  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          if (pre_acc) begin
            pend_q <= 1'b1;
            tgt_q  <= tgt_new;
            if (wr_q) nb_q <= cnt_n;
          end
          if ((cnt_n >= bl_w) && !(pend_q | pre_acc)) run_q <= 1'b0;
        end
      end
    end
  end

  assign push      = run_q & ~wr_q & (cnt_q < bl_w);
  assign wr_take_o = run_q & wr_q & (cnt_q < bl_w) & (cnt_q < nb_q);
  assign dqm_o     = run_q & wr_q & (cnt_q < bl_w) & (cnt_q >= nb_q);

  assign cs_n_o      = cs_q;
  assign ras_n_o     = cmd_q[2];
  assign cas_n_o     = cmd_q[1];
  assign we_n_o      = cmd_q[0];
  assign term_late_o = late_q;
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int RAS_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             act_i,
  input logic             start_i,
  input logic             term_i,
  input logic             term_pre_i,
  input logic [RAS_W-1:0] tras_i,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic             dqm_o,
  input logic             wr_take_o,
  input logic             term_late_o,
  input logic             busy_o
);
  logic [RAS_W-1:0] since_q;
  logic [2:0]       pins;
  logic             is_bst, is_pre, is_col;

  assign pins   = {ras_n_o, cas_n_o, we_n_o};
  assign is_bst = pins == 3'b110;
  assign is_pre = pins == 3'b010;
  assign is_col = (pins == 3'b101) || (pins == 3'b100);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= '1;
    else if (act_i)           since_q <= RAS_W'(1);
    else if (since_q != '1)   since_q <= since_q + 1'b1;
  end

  p_cmd_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> ($past(start_i) && !$past(busy_o)));

  p_stop_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bst |-> ($past(term_i) && !$past(term_pre_i)));

  p_stop_no_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bst |-> (!wr_take_o && !dqm_o));

  p_mask_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_o |-> !wr_take_o);

  p_pre_tras_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (since_q >= tras_i));

  p_late_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_late_o |-> $past(term_i));
endmodule

bind sdram_burst_term sbt_checker #(.RAS_W(RAS_W)) u_chk (.*);

// File: tb/sdram_burst_term_tb_top.sv
module sdram_burst_term_tb_top;
  localparam int NC = 24;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       act, start, start_wr, term, term_pre, cas_lat3;
  logic [1:0] bl_sel, trdl;
  logic [5:0] tras;
  logic       cs_n, ras_n, cas_n, we_n, dqm, take, rv, late, busy;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sdram_burst_term dut_i (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .start_i(start), .start_wr_i(start_wr),
    .bl_sel_i(bl_sel), .term_i(term), .term_pre_i(term_pre), .cas_lat3_i(cas_lat3),
    .trdl_i(trdl), .tras_i(tras), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .dqm_o(dqm), .wr_take_o(take), .rvalid_o(rv), .term_late_o(late),
    .busy_o(busy)
  );

  // bit order: cs_n ras_n cas_n we_n dqm take rvalid late busy
  task automatic cmp(input string tag, input int cyc, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic run_case(input int wr, input int bls, input int cl3, input int has, input int tc,
                          input int pre, input int trdl_v, input int tras_v, input int restart,
                          input string tag);
    int bl, cl, c0, nb, endrel, p, last, step;
    bit accd;
    logic [2:0] ecmd [NC];
    bit edqm [NC], etake [NC], erv [NC], elate [NC], ebusy [NC];
    bl = 1 << bls;
    cl = (cl3 != 0) ? 3 : 2;
    c0 = 2;
    for (int j = 0; j < NC; j++) begin
      ecmd[j] = 3'b111; edqm[j] = 0; etake[j] = 0; erv[j] = 0; elate[j] = 0; ebusy[j] = 0;
    end
    ecmd[c0] = (wr != 0) ? 3'b100 : 3'b101;
    accd   = (has != 0) && (tc >= 0) && (tc <= bl - 2);
    nb     = bl;
    endrel = bl - 1;
    if (accd && pre == 0) begin
      ecmd[c0+tc+1] = 3'b110;
      nb = tc + 1;
      endrel = tc;
    end else if (accd) begin
      step = (wr != 0) ? trdl_v : 1;
      p = tc + step;
      if (tras_v - c0 > p) p = tras_v - c0;
      ecmd[c0+p] = 3'b010;
      endrel = p - 1;
      if (wr != 0) begin
        nb = tc + 1;
        for (int i = tc + 1; i < bl && i < p; i++) edqm[c0+i] = 1;
      end else nb = (p < bl) ? p : bl;
    end
    if (has != 0 && !accd) elate[c0+tc+1] = 1;
    for (int i = 0; i < nb; i++) begin
      if (wr != 0) etake[c0+i] = 1;
      else         erv[c0+cl+i] = 1;
    end
    last = c0 + endrel;
    if (wr == 0 && c0 + cl + nb - 1 > last) last = c0 + cl + nb - 1;
    for (int j = c0; j <= last; j++) ebusy[j] = 1;

    for (int j = 0; j < NC; j++) begin
      @(negedge clk);
      cmp(tag, j, {cs_n, ras_n, cas_n, we_n, dqm, take, rv, late, busy},
          {1'b0, ecmd[j], edqm[j], etake[j], erv[j], elate[j], ebusy[j]});
      act      = (j == 0);
      start    = (j == 1) || (restart != 0 && j == c0 + 1);
      start_wr = wr[0];
      bl_sel   = bls[1:0];
      cas_lat3 = cl3[0];
      term     = (has != 0) && (j == c0 + tc);
      term_pre = pre[0];
      trdl     = trdl_v[1:0];
      tras     = tras_v[5:0];
    end
  endtask

  initial begin
    act = 0; start = 0; start_wr = 0; term = 0; term_pre = 0; cas_lat3 = 0;
    bl_sel = 0; trdl = 1; tras = 0;
    repeat (3) @(negedge clk);
    cmp("R1", -1, {cs_n, ras_n, cas_n, we_n, dqm, take, rv, late, busy}, 9'b1_111_00000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R1", 0, {cs_n, ras_n, cas_n, we_n, dqm, take, rv, late, busy}, 9'b0_111_00000);

    for (int wr = 0; wr < 2; wr++)
      for (int bls = 0; bls < 4; bls++)
        for (int cl3 = 0; cl3 < 2; cl3++)
          for (int pre = 0; pre < 2; pre++) begin
            run_case(wr, bls, cl3, 0, 0, pre, 1, 0, 0, (wr != 0) ? "R3" : "R4");
            for (int tc = -1; tc <= (1 << bls); tc++) begin
              int tr, tv, st;
              string tg;
              tv = (tc % 2 != 0) ? 9 : 0;
              tr = 1 + ((tc + 1) % 3);
              st = (wr != 0) ? tr : 1;
              if (tc < 0 || tc > (1 << bls) - 2) tg = "R10";
              else if (pre != 0 && tv - 2 > tc + st) tg = "R9";
              else if (wr != 0) tg = (pre != 0) ? "R7" : "R5";
              else tg = (pre != 0) ? "R8" : "R6";
              run_case(wr, bls, cl3, 1, tc, pre, tr, tv, 0, tg);
            end
          end

    run_case(1, 2, 0, 0, 0, 0, 1, 0, 1, "R2");
    run_case(0, 2, 1, 0, 0, 0, 1, 0, 1, "R2");
    run_case(0, 3, 0, 0, 0, 0, 1, 0, 1, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule